// File: doc/BRIEF.md
# Serial Command Word Receiver

This block receives 12-bit command words over a three-wire serial link: a serial clock, a data line and an active-low chip select. All three pins come from outside the system clock domain. They pass through two-flop synchronisers, and the block then detects their edges in the system clock. While chip select is low, each serial clock rising edge shifts the data bit into a 12-bit register. When chip select rises, the last twelve bits are handed to the command decoder as a parallel word, together with a one-cycle strobe. A frame whose length is not a multiple of twelve simply yields its last twelve bits.

The bit shifted out of the far end of the register drives a serial output, so that several receivers can be chained. This output changes on one serial clock edge only, and a latched phase setting chooses which edge. With the rising-edge phase, the output trails the input by twelve serial clocks. With the falling-edge phase, it trails by twelve and a half. The phase is the rising edge after reset. It changes only when the decoder presents a valid phase request. The serial output is always driven and does not move while chip select is high.

The system clock must run at least four times faster than the serial clock.

Top module: `cmd_shift_rx`

## Requirements
- R1: After reset, word is 0, word_valid is 0, dout is 0 and the output phase is rising-edge (phase value 1).
- R2: The first bit shifted in a frame lands in word[11] and the last in word[0] (field order A1, A0, C1, C0, D7..D0 from bit 11 down to bit 0).
- R3: Each rising edge of cs_n produces exactly one word_valid pulse, one system clock long, and word carries the new value in that cycle.
- R4: A frame of any length yields the last 12 bits shifted in; bits from earlier frames (or 0 after reset) fill the older positions of a short frame.
- R5: Serial clock edges while cs_n is high shift nothing and leave dout, word and the shift register unchanged.
- R6: With phase 1, dout changes only on serial clock rising edges; after the n-th rising edge of the stream it equals the bit taken at rising edge n-12.
- R7: With phase 0, dout changes only on serial clock falling edges; after the falling edge that follows rising edge n, it equals the bit taken at rising edge n-12.
- R8: The phase takes set_mode only in a cycle with set_mode_valid high, and otherwise keeps its value.
- R9: dout keeps its value while cs_n is high.
- R10: word keeps its value between word_valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock pin, idles low |
| cs_n_i | input | 1 | Chip select pin, active low |
| din_i | input | 1 | Serial data pin |
| set_mode_valid | input | 1 | Phase request strobe from the decoder |
| set_mode | input | 1 | Requested phase: 1 rising edge, 0 falling edge |
| word_valid | output | 1 | One-cycle strobe for a received word |
| word | output | 12 | Last received command word |
| dout | output | 1 | Serial output for chaining |

## Verification
Random frames of exactly twelve bits check the bit order and the basic strobe. Frames of random length, both shorter and longer than twelve, show whether the block keeps the last twelve bits rather than the first twelve, and whether it keeps contents across frames. The output is compared with a bit history after every serial clock edge, in both phases. This exposes an off-by-one in the chain delay or the wrong edge being used, and a phase request without its strobe shows whether the phase is really latched. Serial clock pulses with chip select high are followed by a frame whose word still reveals the untouched register contents.

// File: rtl/cmd_shift_pkg.sv
package cmd_shift_pkg;

  localparam int CMD_W       = 12;
  localparam int SYNC_DEPTH  = 2;

  typedef enum logic {
    PHASE_FALL = 1'b0,
    PHASE_RISE = 1'b1
  } dout_phase_e;

  localparam dout_phase_e PHASE_AT_RESET = PHASE_RISE;

endpackage

// File: rtl/cmd_sync.sv
module cmd_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
        else        chain <= {chain[STAGES-2:0], async_i[g]};
      end
      assign sync_o[g] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cmd_edge.sv
module cmd_edge #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;

endmodule

// File: rtl/cmd_shift_core.sv
module cmd_shift_core #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              commit_en,
  input  logic              din_bit,
  output logic              msb_o,
  output logic              spill_o,
  output logic [WORD_W-1:0] word_o,
  output logic              word_valid_o
);

  function automatic logic [WORD_W-1:0] push_bit(input logic [WORD_W-1:0] cur,
                                                 input logic b);
    return {cur[WORD_W-2:0], b};
  endfunction

  function automatic logic oldest_bit(input logic [WORD_W-1:0] cur);
    return cur[WORD_W-1];
  endfunction

  logic [WORD_W-1:0] shreg_q;
  logic              spill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      spill_q <= 1'b0;
    end else if (sample_en) begin
      shreg_q <= push_bit(shreg_q, din_bit);
      spill_q <= oldest_bit(shreg_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o       <= '0;
      word_valid_o <= 1'b0;
    end else begin
      word_valid_o <= commit_en;
      if (commit_en) word_o <= shreg_q;
    end
  end

  assign msb_o   = oldest_bit(shreg_q);
  assign spill_o = spill_q;

endmodule

// File: rtl/cmd_dout_stage.sv
module cmd_dout_stage
  import cmd_shift_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_en,
  input  logic fall_en,
  input  logic msb_i,
  input  logic spill_i,
  input  logic set_mode_valid,
  input  logic set_mode,
  output logic mode_o,
  output logic dout_o
);

  dout_phase_e phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= PHASE_AT_RESET;
    else if (set_mode_valid) phase_q <= dout_phase_e'(set_mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_o <= 1'b0;
    end else if (phase_q == PHASE_RISE) begin
      if (rise_en) dout_o <= msb_i;
    end else begin
      if (fall_en) dout_o <= spill_i;
    end
  end

  assign mode_o = phase_q;

endmodule

// File: rtl/cmd_shift_rx.sv
module cmd_shift_rx
  import cmd_shift_pkg::*;
#(
  parameter int WORD_W     = CMD_W,
  parameter int SYNC_STAGE = SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              din_i,
  input  logic              set_mode_valid,
  input  logic              set_mode,
  output logic              word_valid,
  output logic [WORD_W-1:0] word,
  output logic              dout
);

  localparam int PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b010;

  logic [PIN_N-1:0] pins_s;
  logic sclk_s, cs_s, din_s;
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic frame_active;
  logic shift_en, out_rise_en, out_fall_en;
  logic msb, spill;
  logic mode_q;

  cmd_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGE), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({din_i, cs_n_i, sclk_i}),
    .sync_o(pins_s)
  );

  assign sclk_s = pins_s[0];
  assign cs_s   = pins_s[1];
  assign din_s  = pins_s[2];

  cmd_edge #(.RST_VAL(1'b0)) u_sclk_edge (
    .clk(clk), .rst_n(rst_n), .level_i(sclk_s),
    .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  cmd_edge #(.RST_VAL(1'b1)) u_cs_edge (
    .clk(clk), .rst_n(rst_n), .level_i(cs_s),
    .rise_o(cs_rise), .fall_o(cs_fall)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_active <= 1'b0;
    else if (cs_fall) frame_active <= 1'b1;
    else if (cs_rise) frame_active <= 1'b0;
  end

  assign shift_en    = sclk_rise & frame_active;
  assign out_rise_en = sclk_rise & frame_active;
  assign out_fall_en = sclk_fall & frame_active;

  cmd_shift_core #(.WORD_W(WORD_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .sample_en(shift_en), .commit_en(cs_rise), .din_bit(din_s),
    .msb_o(msb), .spill_o(spill),
    .word_o(word), .word_valid_o(word_valid)
  );

  cmd_dout_stage u_dout (
    .clk(clk), .rst_n(rst_n),
    .rise_en(out_rise_en), .fall_en(out_fall_en),
    .msb_i(msb), .spill_i(spill),
    .set_mode_valid(set_mode_valid), .set_mode(set_mode),
    .mode_o(mode_q), .dout_o(dout)
  );

endmodule

// File: rtl/cmd_shift_rx_checker.sv
module cmd_shift_rx_checker #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_active,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              cs_rise,
  input logic              mode_q,
  input logic              set_mode_valid,
  input logic              dout,
  input logic [WORD_W-1:0] word,
  input logic              word_valid
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (word == '0 && !word_valid && !dout && mode_q));

  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

  assert_pulse_follows_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> word_valid);

  assert_idle_clock_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !((sclk_rise || sclk_fall) && frame_active) |=> $stable(dout));

  assert_rise_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && sclk_fall) |=> $stable(dout));

  assert_fall_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && sclk_rise) |=> $stable(dout));

  assert_mode_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !set_mode_valid |=> $stable(mode_q));

  assert_dout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_active && !cs_rise) |=> $stable(dout));

  assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(word));

endmodule

bind cmd_shift_rx cmd_shift_rx_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_active(frame_active),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_rise(cs_rise),
  .mode_q(mode_q), .set_mode_valid(set_mode_valid), .dout(dout),
  .word(word), .word_valid(word_valid)
);

// File: tb/cmd_shift_rx_bench.sv
module cmd_shift_rx_bench;

  localparam int W = 12;
  localparam int HMAX = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic smv = 1'b0, sm = 1'b0;
  logic word_valid, dout;
  logic [W-1:0] word;

  always #5 clk = ~clk;

  cmd_shift_rx u_cmd_shift_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
    .set_mode_valid(smv), .set_mode(sm),
    .word_valid(word_valid), .word(word), .dout(dout)
  );

  int tests = 0, fails = 0, pulses = 0, n = 0;
  bit hist [HMAX];
  bit phase = 1'b1;
  logic [W-1:0] last_word = '0;

  always @(posedge clk) if (rst_n && word_valid) pulses++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit h(input int i);
    return (i < 1) ? 1'b0 : hist[i];
  endfunction

  function automatic logic [W-1:0] expect_word(input int cnt);
    logic [W-1:0] r = '0;
    for (int k = 0; k < W; k++) r[W-1-k] = h(cnt - W + 1 + k);
    return r;
  endfunction

  task automatic wait_clk(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    bit exp_r;
    din = b; wait_clk(4);
    sclk = 1'b1; wait_clk(4);
    n++; hist[n] = b;
    exp_r = phase ? h(n - 12) : h(n - 13);
    check(dout == exp_r, phase ? "R6 dout after rise" : "R7 dout held at rise", dout, exp_r);
    sclk = 1'b0; wait_clk(4);
    check(dout == h(n - 12), phase ? "R6 dout held at fall" : "R7 dout after fall", dout, h(n - 12));
  endtask

  task automatic send_frame(input int nbits, input logic [31:0] bits);
    int p0;
    logic d0;
    logic [W-1:0] ew;
    cs_n = 1'b0; wait_clk(4);
    for (int i = 0; i < nbits; i++) send_bit(bits[nbits-1-i]);
    p0 = pulses; d0 = dout;
    cs_n = 1'b1; wait_clk(6);
    ew = expect_word(n);
    check(word == ew, (nbits == W) ? "R2 word bit order" : "R4 last twelve bits", word, ew);
    check(pulses == p0 + 1, "R3 one strobe per frame", pulses - p0, 1);
    check(dout == d0, "R9 dout held after cs high", dout, d0);
    last_word = word;
    wait_clk(4);
    check(word == last_word, "R10 word held", word, last_word);
  endtask

  task automatic pulse_mode(input bit v, input bit m);
    @(negedge clk); smv = v; sm = m;
    @(negedge clk); smv = 1'b0; sm = 1'b0;
    if (v) phase = m;
  endtask

  task automatic idle_clocks(input int cnt);
    logic d0;
    logic [W-1:0] w0;
    int p0;
    d0 = dout; w0 = word; p0 = pulses;
    for (int i = 0; i < cnt; i++) begin
      din = 1'($urandom); wait_clk(4);
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0; wait_clk(4);
    end
    check(dout == d0, "R5 dout untouched by idle clocks", dout, d0);
    check(word == w0, "R5 word untouched by idle clocks", word, w0);
    check(pulses == p0, "R5 no strobe from idle clocks", pulses - p0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    check(word == '0, "R1 word at reset", word, 0);
    check(!word_valid, "R1 strobe at reset", word_valid, 0);
    check(!dout, "R1 dout at reset", dout, 0);

    // R4 short frame right after reset: zeros fill the older bits
    send_frame(5, 32'h15);
    // R2 directed full word
    send_frame(12, 32'hA5C);
    for (int f = 0; f < 8; f++) send_frame(12, $urandom);
    for (int f = 0; f < 6; f++) send_frame(1 + ($urandom % 30), $urandom);

    idle_clocks(5);
    send_frame(7, $urandom);

    // R7 switch to falling-edge phase
    pulse_mode(1'b1, 1'b0);
    for (int f = 0; f < 6; f++) send_frame(3 + ($urandom % 28), $urandom);
    // R8 request without strobe keeps falling phase
    pulse_mode(1'b0, 1'b1);
    send_frame(12, $urandom);
    idle_clocks(3);
    send_frame(20, $urandom);
    // R8 back to rising phase with strobe
    pulse_mode(1'b1, 1'b1);
    for (int f = 0; f < 5; f++) send_frame(1 + ($urandom % 30), $urandom);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule